// File: doc/BRIEF.md
# DMA Handshake Slave with End-of-Transfer Control

This block sits on the peripheral side of a request/acknowledge DMA link. It moves 16-bit words between an internal buffer word port and an external host data bus. The block raises a request line to ask the host for service. The host answers with an acknowledge together with a read or a write strobe, and that same cycle is one data phase. A host write stores the bus word in the buffer. A host read returns the buffer word on the output bus. The buffer address is the index of the word within the transfer.

A transfer runs until an end-of-transfer condition. That condition comes from one of two sources, chosen by a configuration bit. The first is a pulse on a dedicated host input. The second is an internal word counter that matches a programmed transfer count. A second configuration bit selects how many words each request covers: one word in single-cycle mode, or a burst of 4 or 8 words. A transfer of N data phases moves 2N bytes. The configuration register and the transfer count register are reached through a small register port. Each register is written at one address and read back at another.

Top module: `dma_hs_slave`

## Requirements
- R1: After reset, `dma_req` and `xfer_done` are 0, and reads of addresses 0x21 and 0x22 return 0.
- R2: A write to 0xA1 sets the configuration and a write to 0xA2 sets the transfer count. These read back at 0x21 and 0x22. The configuration fields are: bit 0 enable, bit 1 internal-count termination, bit 2 burst mode, bit 3 burst length 8 (burst length 4 when this bit is 0). A write to a read address such as 0x21 changes nothing.
- R3: In single-cycle mode, `dma_req` is 1 from the cycle after an enabling configuration write. It drops for exactly one cycle after each data phase, then returns.
- R4: In burst mode, `dma_req` stays 1 across 4 data phases, or across 8 when bit 3 is set. After the last phase of the burst it drops for one cycle, then returns.
- R5: A data phase needs `dma_req`, `dma_ack` and exactly one of `host_rd` or `host_wr`. An acknowledge with no strobe, or with both strobes, causes no buffer access, does not advance the count and does not change `dma_req`.
- R6: In a host write phase, `buf_we` is 1 and `buf_wdata` equals `host_din`. In a host read phase, `buf_re` is 1 and `host_dout` equals `buf_rdata` in that same cycle. In both cases `buf_addr` is the index of the word within the transfer, starting at 0.
- R7: With bit 1 clear, a data phase sampled with `host_eot` high still completes its word. From the next cycle `dma_req` is 0 and `xfer_done` is 1.
- R8: With bit 1 set, the transfer ends after exactly the programmed count of data phases, and `host_eot` has no effect.
- R9: With bit 1 set and a transfer count of 0, enabling gives `xfer_done` = 1 on the next cycle, and `dma_req` never rises.
- R10: Once a transfer has ended, `dma_req` stays 0 until another configuration write with bit 0 set. That write clears `xfer_done` and restarts the word index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| dma_req | output | 1 | Service request to the host |
| dma_ack | input | 1 | Host acknowledge |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_eot | input | 1 | External end-of-transfer |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| buf_addr | output | 16 | Buffer word address |
| buf_we | output | 1 | Buffer write enable |
| buf_re | output | 1 | Buffer read enable |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data |
| xfer_done | output | 1 | Transfer ended flag |

## Verification
The assertions take the following for granted about the inputs. Register writes never coincide with a data phase. The transfer count is not rewritten while a transfer is running. Every input is stable around the rising edge. The bench keeps to these rules in several ways. It changes every input only on the falling edge and holds each strobe for exactly one cycle. It programs the transfer count only while the block is idle. It issues a data phase only after it has seen the request high. The checks that stimulus is ignored, an acknowledge alone or both strobes together, are driven while the request is high. Those cycles would otherwise count as a phase.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  // Configuration fields; bit 0 is enable, bit 3 is the long-burst select.
  typedef struct packed {
    logic burst8;
    logic burst;
    logic int_eot;
    logic enable;
  } dma_cfg_t;

  localparam int CFG_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } dma_st_e;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CFG_RD = 8'h21,
  parameter logic [ADDR_W-1:0] CFG_WR = 8'hA1,
  parameter logic [ADDR_W-1:0] TC_RD  = 8'h22,
  parameter logic [ADDR_W-1:0] TC_WR  = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output dma_cfg_t          cfg,
  output dma_cfg_t          new_cfg,
  output logic [DATA_W-1:0] tcount,
  output logic              start,
  output logic              stop
);

  logic cfg_hit, tc_hit;

  assign cfg_hit = reg_wr && (reg_addr == CFG_WR);
  assign tc_hit  = reg_wr && (reg_addr == TC_WR);
  assign new_cfg = dma_cfg_t'(reg_wdata[CFG_BITS-1:0]);
  assign start   = cfg_hit && new_cfg.enable;
  assign stop    = cfg_hit && !new_cfg.enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      tcount <= '0;
    end else begin
      if (cfg_hit) cfg <= new_cfg;
      if (tc_hit)  tcount <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_RD)     reg_rdata[CFG_BITS-1:0] = cfg;
    else if (reg_addr == TC_RD) reg_rdata = tcount;
  end

  a_r2_cfg_written: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (cfg == $past(new_cfg)));
  a_r2_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(cfg));
  a_r2_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_hit |=> $stable(tcount));

endmodule

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] tcount,
  output logic [CNT_W-1:0] count,
  output logic             last_word,
  output logic             tc_zero
);

  // True when the word now moving is the final one of the programmed count.
  function automatic logic is_terminal(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] t);
    return (c + CNT_W'(1)) == t;
  endfunction

  assign last_word = is_terminal(count, tcount);
  assign tc_zero   = (tcount == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end

  a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (count == $past(count) + CNT_W'(1)));
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(count));

endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_hs_pkg::*;
#(
  parameter int SHORT_BURST = 4,
  parameter int LONG_BURST  = 8,
  localparam int BEAT_W = $clog2(LONG_BURST + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     stop,
  input  dma_cfg_t cfg,
  input  dma_cfg_t new_cfg,
  input  logic     tc_zero,
  input  logic     last_word,
  input  logic     host_phase,
  input  logic     host_eot,
  output logic     dreq,
  output logic     phase,
  output logic     done
);

  dma_st_e           state;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] wpr;
  logic              end_now, closes;

  function automatic logic [BEAT_W-1:0] words_per_request(input dma_cfg_t c);
    if (!c.burst)  return BEAT_W'(1);
    if (c.burst8)  return BEAT_W'(LONG_BURST);
    return BEAT_W'(SHORT_BURST);
  endfunction

  function automatic logic closes_request(input logic [BEAT_W-1:0] b,
                                          input logic [BEAT_W-1:0] w);
    return (b + BEAT_W'(1)) == w;
  endfunction

  assign dreq    = (state == ST_REQ);
  assign phase   = dreq && host_phase;
  assign wpr     = words_per_request(cfg);
  assign closes  = closes_request(beat, wpr);
  assign end_now = phase && (cfg.int_eot ? last_word : host_eot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
      done  <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else if (start) begin
      beat <= '0;
      if (new_cfg.int_eot && tc_zero) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else begin
        state <= ST_REQ;
        done  <= 1'b0;
      end
    end else begin
      case (state)
        ST_REQ: if (phase) begin
          if (end_now) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            beat  <= '0;
          end else if (closes) begin
            state <= ST_GAP;
            beat  <= '0;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        ST_GAP:  state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat < wpr);
  a_r3_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && !cfg.burst && !start && !stop) |=> !dreq);
  a_r3_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && !start && !stop) |=> dreq);
  a_r7_ext_end: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && !cfg.int_eot && host_eot && !start && !stop) |=> (done && !dreq));
  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && new_cfg.int_eot && tc_zero) |=> (done && !dreq));
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !dreq);

endmodule

// File: rtl/dma_hs_slave.sv
module dma_hs_slave
  import dma_hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SHORT_BURST = 4,
  parameter int LONG_BURST  = 8,
  parameter logic [ADDR_W-1:0] CFG_RD = 8'h21,
  parameter logic [ADDR_W-1:0] CFG_WR = 8'hA1,
  parameter logic [ADDR_W-1:0] TC_RD  = 8'h22,
  parameter logic [ADDR_W-1:0] TC_WR  = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_eot,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic [DATA_W-1:0] buf_addr,
  output logic              buf_we,
  output logic              buf_re,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              xfer_done
);

  dma_cfg_t          cfg, new_cfg;
  logic [DATA_W-1:0] tcount, count;
  logic              start, stop, last_word, tc_zero;
  logic              host_phase, phase;

  // One strobe exactly, together with the acknowledge.
  assign host_phase = dma_ack && (host_rd ^ host_wr);

  dma_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_RD(CFG_RD), .CFG_WR(CFG_WR), .TC_RD(TC_RD), .TC_WR(TC_WR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg),
    .new_cfg(new_cfg), .tcount(tcount), .start(start), .stop(stop)
  );

  dma_word_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(phase),
    .tcount(tcount), .count(count), .last_word(last_word), .tc_zero(tc_zero)
  );

  dma_req_fsm #(.SHORT_BURST(SHORT_BURST), .LONG_BURST(LONG_BURST)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg(cfg),
    .new_cfg(new_cfg), .tc_zero(tc_zero), .last_word(last_word),
    .host_phase(host_phase), .host_eot(host_eot), .dreq(dma_req),
    .phase(phase), .done(xfer_done)
  );

  assign buf_addr  = count;
  assign buf_we    = phase && host_wr;
  assign buf_re    = phase && host_rd;
  assign buf_wdata = host_din;
  assign host_dout = buf_re ? buf_rdata : '0;

  a_r5_ack_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && (host_rd == host_wr)) |-> (!buf_we && !buf_re));
  a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_we, buf_re}));
  a_r5_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> (!buf_we && !buf_re));

endmodule

// File: tb/dma_hs_slave_tb.sv
`timescale 1ns/100ps
module dma_hs_slave_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dma_req;
  logic        dma_ack = 1'b0, host_rd = 1'b0, host_wr = 1'b0, host_eot = 1'b0;
  logic [15:0] host_din = '0;
  logic [15:0] host_dout, buf_addr, buf_wdata, buf_rdata;
  logic        buf_we, buf_re, xfer_done;
  logic [15:0] mem [0:15];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_wr;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign buf_rdata = mem[buf_addr[3:0]];

  dma_hs_slave u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .dma_ack(dma_ack), .host_rd(host_rd), .host_wr(host_wr),
    .host_eot(host_eot), .host_din(host_din), .host_dout(host_dout),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_re(buf_re),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Register write; ends on the falling edge after it takes effect.
  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic reg_read(input string req, input logic [7:0] a, input logic [15:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
    reg_addr = '0;
  endtask

  // Driver: one data phase, pushing the buffer access it must produce.
  task automatic phase(input bit is_wr, input logic [15:0] d, input bit eot,
                       input logic [15:0] idx, input string tag);
    exp_t e;
    while (!dma_req) @(negedge clk);
    e.is_wr = is_wr; e.addr = idx; e.tag = tag;
    e.data  = is_wr ? d : mem[idx[3:0]];
    exp_q.push_back(e);
    dma_ack = 1'b1; host_wr = is_wr; host_rd = !is_wr; host_din = d; host_eot = eot;
    @(negedge clk);
    dma_ack = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_din = '0; host_eot = 1'b0;
  endtask

  // Monitor: compares every buffer access with the queued expectation.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && (buf_we || buf_re)) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R5 unexpected access actual=%b%b expected=00", buf_we, buf_re);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " R6 direction"}, {15'd0, buf_we}, {15'd0, e.is_wr});
        check({e.tag, " R6 address"}, buf_addr, e.addr);
        check({e.tag, " R6 data"}, e.is_wr ? buf_wdata : host_dout, e.data);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h5000 + 16'(i);
    repeat (3) @(negedge clk);
    check("R1 req", {15'd0, dma_req}, 16'd0);
    check("R1 done", {15'd0, xfer_done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read("R1 cfg read", 8'h21, 16'h0000);
    reg_read("R1 tc read", 8'h22, 16'h0000);

    // R2 register map
    reg_write(8'hA2, 16'd5);
    reg_read("R2 tc readback", 8'h22, 16'd5);
    reg_write(8'h21, 16'h000F);
    reg_read("R2 read address not writable", 8'h21, 16'h0000);
    check("R2 no start from read address", {15'd0, dma_req}, 16'd0);

    // Single-cycle, external end
    reg_write(8'hA1, 16'h0001);
    reg_read("R2 cfg readback", 8'h21, 16'h0001);
    check("R3 req after enable", {15'd0, dma_req}, 16'd1);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    check("R5 ack alone keeps req", {15'd0, dma_req}, 16'd1);
    dma_ack = 1'b1; host_rd = 1'b1; host_wr = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    check("R5 both strobes keep req", {15'd0, dma_req}, 16'd1);
    phase(1'b1, 16'hA000, 1'b0, 16'd0, "R6");
    check("R3 req drops after word", {15'd0, dma_req}, 16'd0);
    @(negedge clk);
    check("R3 req returns", {15'd0, dma_req}, 16'd1);
    phase(1'b1, 16'hA001, 1'b0, 16'd1, "R6");
    phase(1'b1, 16'hA002, 1'b1, 16'd2, "R7");
    check("R7 req low after end", {15'd0, dma_req}, 16'd0);
    check("R7 done", {15'd0, xfer_done}, 16'd1);
    repeat (5) @(negedge clk);
    check("R10 stays idle", {15'd0, dma_req}, 16'd0);
    check("R10 done held", {15'd0, xfer_done}, 16'd1);

    // Burst of 4, internal count 6, host reads, end pin ignored
    reg_write(8'hA2, 16'd6);
    reg_write(8'hA1, 16'h0007);
    check("R10 done cleared", {15'd0, xfer_done}, 16'd0);
    for (int k = 0; k < 6; k++) begin
      phase(1'b0, 16'h0, (k == 1), 16'(k), "R10 R8");
      if (k < 3 || k == 4) check("R4 req held in burst", {15'd0, dma_req}, 16'd1);
      if (k == 1) check("R8 end pin ignored", {15'd0, xfer_done}, 16'd0);
      if (k == 3) check("R4 drop after 4", {15'd0, dma_req}, 16'd0);
    end
    check("R8 done after count", {15'd0, xfer_done}, 16'd1);
    check("R8 req low", {15'd0, dma_req}, 16'd0);

    // Burst of 8, external end
    reg_write(8'hA1, 16'h000D);
    for (int k = 0; k < 9; k++) begin
      phase(1'b1, 16'hB000 + 16'(k), (k == 8), 16'(k), "R10 R4");
      if (k < 7) check("R4 req held in long burst", {15'd0, dma_req}, 16'd1);
      if (k == 7) check("R4 drop after 8", {15'd0, dma_req}, 16'd0);
    end
    check("R7 done long burst", {15'd0, xfer_done}, 16'd1);

    // Zero count, internal mode
    reg_write(8'hA2, 16'd0);
    reg_write(8'hA1, 16'h0003);
    check("R9 done at once", {15'd0, xfer_done}, 16'd1);
    check("R9 no req", {15'd0, dma_req}, 16'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 req stays low", {15'd0, dma_req}, 16'd0);
    end

    #2;
    check("R6 all expected accesses seen", 16'(exp_q.size()), 16'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule